// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets an on-chip requester using a valid/ready handshake run read and write cycles on an external asynchronous static RAM of 512K words by 8 bits. The RAM is driven through an active-low chip select, an active-high chip select, an active-low output enable, an active-low write strobe and a shared 8-bit data bus. The bus is presented to the pad ring as separate data-out, data-in and drive-enable signals.

Each interval the RAM needs is converted into a whole number of clock cycles. The controller uses the clock period parameter and a speed-grade parameter, which selects a 55 ns or a 70 ns timing set. The intervals are read cycle, write pulse, address-to-end-of-write, data setup, write cycle and output float time. Each conversion rounds up, with a floor of one cycle. The controller holds address, both selects and write data stable for a whole access. It returns read data together with a one-cycle done pulse. Between accesses it parks the RAM in standby.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, `mem_ce_n_o`=1, `mem_ce_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1 and `mem_dq_oe_o`=0. After reset, `req_ready_o`=1.
- R2: A read accepted on a clock edge (`req_valid_i`=1, `req_ready_o`=1, `req_write_i`=0) opens a read phase on the next cycle. The phase lasts RD cycles, which is 6 at 10 ns on the fast grade. Throughout it `mem_ce_n_o`=0, `mem_ce_o`=1, `mem_oe_n_o`=0, `mem_we_n_o`=1 and `mem_dq_oe_o`=0, and `mem_addr_o` holds the accepted address.
- R3: Read data is sampled from `mem_dq_i` in the last read-phase cycle. It appears on `rsp_rdata_o` in the next cycle, together with a one-cycle `rsp_done_o`, and stays unchanged until the next read completes.
- R4: A write (`req_write_i`=1) drives `mem_we_n_o`=0 for WL cycles, starting the cycle after acceptance. WL is the largest of the rounded write-pulse, address-to-end, data-setup and (write-cycle minus one) counts, which is 5 at 10 ns on the fast grade. During these cycles both selects are active, `mem_oe_n_o`=1, `mem_dq_oe_o`=1, and `mem_addr_o` and `mem_dq_o` hold the accepted address and data.
- R5: When `mem_we_n_o` rises, one recovery cycle follows with selects, address, data and `mem_dq_oe_o`=1 all still held. In the next cycle the bus is released (`mem_dq_oe_o`=0) and `rsp_done_o` pulses.
- R6: After a read, at least TA cycles pass with `mem_oe_n_o`=1 and `mem_dq_oe_o`=0 before write data is driven. TA is the rounded output float time, which is 2 at 10 ns on the fast grade. `req_ready_o` is therefore 0 in the done cycle of a read.
- R7: In the done cycle of a write, `req_ready_o`=1, so a new request can be accepted with no idle gap.
- R8: While an access is in progress (`mem_ce_n_o`=0), `req_ready_o`=0 and a pending request does not alter the address or strobes. That request is taken only once `req_ready_o` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 8 | Write data |
| rsp_done_o | output | 1 | One-cycle pulse when an access finishes |
| rsp_rdata_o | output | 8 | Data from the latest read |
| mem_addr_o | output | 19 | RAM address |
| mem_ce_n_o | output | 1 | RAM select, active low |
| mem_ce_o | output | 1 | RAM select, active high |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the RAM |

## Verification
The bench runs a write directly after a read. A controller that drove write data too early would show fewer than TA floating cycles, or would have `req_ready_o` high in the read's done cycle. Each strobe window is measured in cycles. A read phase one cycle short, or a write strobe that did not cover the address-to-end interval, would show up as a length other than 6 or 5. The bench also checks that the bus stays driven through the recovery cycle, and that a request held pending during an access neither moves the address nor shortens the strobe. It checks that read data is held across following writes, so a controller that reloaded the data register on every done pulse would be caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} cyc_state_e;

  function automatic int ns_to_cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // grade 0: 55 ns set, grade 1: 70 ns set
  function automatic int rd_cycles(int grade, int per);
    return ns_to_cyc(grade != 0 ? 70 : 55, per);
  endfunction

  function automatic int we_low_cycles(int grade, int per);
    int pulse, aw, ds, wc;
    pulse = ns_to_cyc(grade != 0 ? 50 : 40, per);
    aw    = ns_to_cyc(grade != 0 ? 60 : 50, per);
    ds    = ns_to_cyc(grade != 0 ? 30 : 25, per);
    wc    = ns_to_cyc(grade != 0 ? 70 : 55, per) - 1;
    return imax(imax(pulse, aw), imax(ds, imax(wc, 1)));
  endfunction

  function automatic int float_cycles(int grade, int per);
    return ns_to_cyc(grade != 0 ? 25 : 20, per);
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int WL_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       write_i,
  output cyc_state_e state_o,
  output logic       we_low_o,
  output logic       capture_o,
  output logic       finish_o
);
  localparam int MAXC  = (RD_CYC > WL_CYC) ? RD_CYC : WL_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  cyc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_last, wr_last;

  assign rd_last   = (state_q == ST_READ)  && (cnt_q == CNT_W'(RD_CYC - 1));
  assign wr_last   = (state_q == ST_WRITE) && (cnt_q == CNT_W'(WL_CYC));
  assign capture_o = rd_last;
  assign finish_o  = rd_last || wr_last;
  assign we_low_o  = (state_q == ST_WRITE) && (cnt_q < CNT_W'(WL_CYC));
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= write_i ? ST_WRITE : ST_READ;
        end
        default: begin
          if (finish_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // an access never outlasts its count
  p_bounded_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (cnt_q <= CNT_W'(MAXC)));
  p_start_leaves_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_turn_gap.sv
module sram_turn_gap #(
  parameter int TA_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_end_i,
  output logic busy_o
);
  generate
    if (TA_CYC > 1) begin : g_gap
      localparam int GW = $clog2(TA_CYC);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          gap_q <= '0;
        else if (read_end_i)  gap_q <= GW'(TA_CYC - 1);
        else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      end
      assign busy_o = (gap_q != '0);

      p_gap_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        read_end_i |=> busy_o);
    end else begin : g_nogap
      assign busy_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int WL_CYC = we_low_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int TA_CYC = float_cycles(SPEED_GRADE, CLK_PERIOD_NS);

  cyc_state_e        state;
  logic              we_low, capture, finish, gap_busy, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;

  assign req_ready_o = (state == ST_IDLE) && !gap_busy;
  assign accept      = req_valid_i && req_ready_o;

  sram_seq_fsm #(.RD_CYC(RD_CYC), .WL_CYC(WL_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .write_i   (req_write_i),
    .state_o   (state),
    .we_low_o  (we_low),
    .capture_o (capture),
    .finish_o  (finish)
  );

  sram_turn_gap #(.TA_CYC(TA_CYC)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .read_end_i (capture),
    .busy_o     (gap_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_ce_n_o  = (state == ST_IDLE);
  assign mem_ce_o    = (state != ST_IDLE);
  assign mem_oe_n_o  = (state != ST_READ);
  assign mem_we_n_o  = !we_low;
  assign mem_dq_oe_o = (state == ST_WRITE);
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;

  p_accept_selects_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!mem_ce_n_o && mem_ce_o));
  p_addr_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o));
  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);
  p_capture_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (rsp_done_o && !req_ready_o || rsp_done_o && TA_CYC == 1));
  p_we_rise_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_ce_n_o && $stable(mem_dq_o)));
  p_release_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_dq_oe_o) |-> (rsp_done_o && mem_ce_n_o));
  p_idle_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> (mem_ce_n_o && !mem_ce_o && mem_we_n_o));

endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int RD = 6;
  localparam int WL = 5;
  localparam int TA = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, ce_n, ce, oe_n, we_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_out, dq_in;
  logic [18:0] mem_addr;

  int checks = 0, failures = 0;

  typedef struct {bit wr; logic [7:0] d;} exp_t;
  exp_t sb_q[$];
  logic [7:0] model_mem [256];
  logic [7:0] ref_mem [256];

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_ce_o(ce),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  // RAM model: drives only when selected, reading
  assign dq_in = (!ce_n && ce && !oe_n && we_n) ? model_mem[mem_addr[7:0]] : 8'h5A;
  always @(posedge we_n) if (!ce_n && ce && dq_oe) model_mem[mem_addr[7:0]] = dq_out;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(bit wr, logic [18:0] a, logic [7:0] d);
    exp_t e;
    e.wr = wr;
    e.d  = wr ? 8'h00 : ref_mem[a[7:0]];
    if (wr) ref_mem[a[7:0]] = d;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 19'h2AAAA; req_wdata = 8'hC3;
  endtask

  // monitor
  logic [18:0] acc_addr;
  logic [7:0]  acc_data, last_rd;
  logic        prev_oe_n = 1'b1, prev_we_n = 1'b1, prev_dq_oe = 1'b0, rec = 1'b0, after_rd = 1'b0;
  int rd_len = 0, wl_len = 0, idle_rd = 0;

  always @(negedge clk) if (rst_n) begin
    if (!ce_n) chk(!req_ready, "R8", "ready during access", req_ready, 0);
    if (!oe_n) begin
      rd_len++; idle_rd = 0;
      chk(!ce_n && ce && we_n && !dq_oe, "R2", "read strobes", {ce_n, ce, we_n, dq_oe}, 4'b0110);
      chk(mem_addr == acc_addr, "R2", "read addr", mem_addr, acc_addr);
    end
    if (prev_oe_n == 1'b0 && oe_n) begin
      chk(rd_len == RD, "R2", "read length", rd_len, RD);
      rd_len = 0; after_rd = 1'b1;
    end
    if (oe_n && !dq_oe && after_rd) idle_rd++;
    if (dq_oe && !prev_dq_oe && after_rd) begin
      chk(idle_rd >= TA, "R6", "turnaround gap", idle_rd, TA);
      after_rd = 1'b0;
    end
    if (!we_n) begin
      wl_len++;
      chk(dq_oe && oe_n && !ce_n && ce, "R4", "write strobes", {dq_oe, oe_n, ce_n, ce}, 4'b1101);
      chk(mem_addr == acc_addr && dq_out == acc_data, "R4", "write addr/data", dq_out, acc_data);
    end
    if (rec) begin
      chk(!dq_oe && rsp_done, "R5", "release+done", {dq_oe, rsp_done}, 2'b01);
      chk(ce_n && !ce && oe_n && we_n, "R1", "standby after write", {ce_n, ce, oe_n, we_n}, 4'b1011);
      rec = 1'b0;
    end
    if (prev_we_n == 1'b0 && we_n) begin
      chk(wl_len == WL, "R4", "we low length", wl_len, WL);
      chk(dq_oe && !ce_n && ce && mem_addr == acc_addr && dq_out == acc_data,
          "R5", "recovery hold", dq_oe, 1);
      wl_len = 0; rec = 1'b1;
    end
    if (rsp_done) begin
      if (sb_q.size() == 0) chk(1'b0, "R3", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        if (!e.wr) begin
          chk(rsp_rdata == e.d, "R3", "read data", rsp_rdata, e.d);
          chk(!req_ready, "R6", "ready in read done", req_ready, 0);
          last_rd = e.d;
        end else begin
          chk(req_ready, "R7", "ready in write done", req_ready, 1);
          chk(rsp_rdata == last_rd, "R3", "rdata held", rsp_rdata, last_rd);
        end
      end
    end
    if (req_valid && req_ready) begin
      acc_addr = req_addr; acc_data = req_wdata;
    end
    prev_oe_n = oe_n; prev_we_n = we_n; prev_dq_oe = dq_oe;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 8'(i) ^ 8'hA5;
      ref_mem[i]   = 8'(i) ^ 8'hA5;
    end
    last_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && !ce && oe_n && we_n && !dq_oe && req_ready && !rsp_done,
        "R1", "reset state", {ce_n, ce, oe_n, we_n, dq_oe, req_ready}, 6'b101101);
    send(1'b0, 19'h00012, 8'h00);  // untouched location
    send(1'b1, 19'h00034, 8'h3C);  // read then write: turnaround (R6)
    send(1'b0, 19'h00034, 8'h00);  // write then read (R7)
    send(1'b1, 19'h7FFFF, 8'hFF);
    send(1'b1, 19'h00000, 8'h00);
    send(1'b1, 19'h45601, 8'h81);  // write after write (R7)
    send(1'b0, 19'h7FFFF, 8'h00);
    send(1'b0, 19'h00000, 8'h00);  // read after read
    send(1'b0, 19'h45601, 8'h00);
    send(1'b1, 19'h12377, 8'h96);
    send(1'b0, 19'h12377, 8'h00);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ce_n && !ce && !dq_oe && req_ready, "R1", "idle standby", {ce_n, ce, dq_oe, req_ready}, 4'b1001);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule